// File: doc/BRIEF.md
# E1 Transmit Signaling Highway Merger

This block assembles one outgoing E1 frame stream at 2.048 Mbit/s from two serial inputs that share a transmit clock. One input carries payload data and the other carries channel-associated signaling. A frame is 32 timeslots of 8 bits. Each bit is given a position from a free-running frame bit counter (0 to 255) and a frame counter (0 to 15). The block uses that position to choose, for every bit, which input feeds the line. Timeslot 16 always comes from the signaling input. Timeslot 0 comes from the data input, or from the signaling input when serial CAS mode is on. Every other timeslot comes from the data input.

A sync pulse aligns both counters, and a programmable offset delays the start of timeslot 0 relative to that pulse. The block cannot recognise alignment frames on its own. It treats even frames of the counted multiframe as alignment frames and odd frames as non-alignment frames, so the sync pulse also fixes that phase. In timeslot 0 a per-position pass mask chooses between two sources: the bit from the selected serial input, or a value from an internal setting register. This covers the international bit of alignment frames and every bit of non-alignment frames. The block also drives a marker output that flags the spare (Sa) bit positions, and two outputs that mark frame starts and multiframe starts.

All outputs are registered. Each one appears one clock after the input bit it belongs to.

Top module: `e1_tx_hwy_merge`

## Requirements
- R1: While `rst` is high all outputs are 0. The first input bit sampled after `rst` falls, with no sync pulse, takes position 0 (timeslot 0, bit 0) of frame 0.
- R2: Every output appears one clock after its input bit. Timeslots other than 0 and 16 copy `data_in` bit for bit, in arrival order, so the MSB goes first.
- R3: Timeslot 16 (positions 128 to 135) copies `sig_in` in every frame.
- R4: The source of timeslot 0 is `data_in` when `cas_serial_en` is 0 and `sig_in` when it is 1. A timeslot-0 bit at position i passes this source whenever `pass_mask[i]` is 1. Position i=0 is sent first.
- R5: Even frames are alignment frames. In these frames, timeslot-0 bits 1 to 7 always pass the source. Bit 0 passes the source if `pass_mask[0]` is 1 and takes `si_fas_val` if it is 0.
- R6: Odd frames are non-alignment frames. In these frames, timeslot-0 bit i takes `nfas_val[i]` when `pass_mask[i]` is 0.
- R7: The bit sampled in the cycle where `sync_in` is high gets position (256 − `ts_offset`) mod 256. Timeslot 0 bit 0 therefore arrives `ts_offset` cycles after the pulse. `ts_offset` must be below 256.
- R8: The position counter advances by one per clock and wraps from 255 to 0. The frame counter advances on each wrap and wraps from 15 to 0. A sync pulse makes the next position 0 start frame 0. `frame_start_out` marks position 0 of every frame, and `mf_start_out` marks position 0 of frame 0.
- R9: `sa_mark_out` is 1 exactly for positions 3 to 7 of timeslot 0 in odd frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 1 | Serial payload input |
| sig_in | input | 1 | Serial signaling input |
| sync_in | input | 1 | Frame and multiframe sync pulse |
| cas_serial_en | input | 1 | 1: timeslot 0 is taken from `sig_in` |
| ts_offset | input | 8 | Bit delay from sync pulse to timeslot 0 start |
| pass_mask | input | 8 | Per timeslot-0 position: 1 passes the serial bit, 0 inserts the register value |
| si_fas_val | input | 1 | Inserted international bit for alignment frames |
| nfas_val | input | 8 | Inserted timeslot-0 bits for non-alignment frames |
| tx_out | output | 1 | Merged serial output |
| sa_mark_out | output | 1 | Marks Sa bit positions on `tx_out` |
| frame_start_out | output | 1 | Marks the first bit of each frame on `tx_out` |
| mf_start_out | output | 1 | Marks the first bit of frame 0 on `tx_out` |

## Verification
The bench covers the following failure modes:
- **Offset arithmetic.** Offsets 0, 1, 37 and 255 are exercised, where an off-by-one in the wrap arithmetic would shift every timeslot boundary by one bit.
- **Frame phase.** Sync pulses that land mid-frame, and full 16-frame multiframes, are exercised. A frame counter preset to the wrong value would swap alignment and non-alignment handling and misplace `mf_start_out`.
- **Timeslot-0 source and mask.** Serial CAS mode is turned on and off, and the masks include all-zero, all-one and mixed values. A design that ignored the mode, inverted the mask, or applied the mask to alignment-word bits 1 to 7 would corrupt specific timeslot-0 bits.
- **Reset start.** The first frame after reset without any sync checks that the counters start at position 0 of frame 0.

// File: rtl/e1_hwy_pkg.sv
package e1_hwy_pkg;

  // Source chosen for one outgoing bit
  typedef enum logic [1:0] {
    SRC_DATA = 2'd0,
    SRC_SIG  = 2'd1,
    SRC_REG  = 2'd2
  } bit_src_e;

endpackage

// File: rtl/e1_hwy_pos_cnt.sv
module e1_hwy_pos_cnt #(
  parameter int FRAME_BITS = 256,
  parameter int FRAMES     = 16,
  localparam int POS_W     = $clog2(FRAME_BITS),
  localparam int FRM_W     = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_in,
  input  logic [POS_W-1:0] ofs,
  output logic [POS_W-1:0] cur_pos,
  output logic [FRM_W-1:0] cur_frm
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);
  localparam logic [FRM_W-1:0] LAST_FRM = FRM_W'(FRAMES - 1);

  logic [POS_W-1:0] pos_q;
  logic [FRM_W-1:0] frm_q;
  logic [31:0]      wrap_v;

  // Position of the bit in the current cycle; a sync pulse overrides the count
  always_comb begin
    wrap_v = 32'(FRAME_BITS) - 32'(ofs);
    if (sync_in) begin
      if (ofs == '0) begin
        cur_pos = '0;
        cur_frm = '0;
      end else begin
        cur_pos = POS_W'(wrap_v);
        cur_frm = LAST_FRM;
      end
    end else begin
      cur_pos = pos_q;
      cur_frm = frm_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      frm_q <= '0;
    end else if (cur_pos == LAST_POS) begin
      pos_q <= '0;
      frm_q <= (cur_frm == LAST_FRM) ? '0 : cur_frm + FRM_W'(1);
    end else begin
      pos_q <= cur_pos + POS_W'(1);
      frm_q <= cur_frm;
    end
  end

endmodule

// File: rtl/e1_hwy_ts0_ins.sv
module e1_hwy_ts0_ins
  import e1_hwy_pkg::*;
#(
  parameter int SLOTS      = 32,
  parameter int SLOT_BITS  = 8,
  parameter int FRAMES     = 16,
  parameter int SIG_TS     = 16,
  parameter int SA_FIRST   = 3,
  localparam int POS_W     = $clog2(SLOTS * SLOT_BITS),
  localparam int FRM_W     = $clog2(FRAMES),
  localparam int BIT_W     = $clog2(SLOT_BITS),
  localparam int TS_W      = POS_W - BIT_W
) (
  input  logic [POS_W-1:0]     cur_pos,
  input  logic [FRM_W-1:0]     cur_frm,
  input  logic                 cas_serial_en,
  input  logic [SLOT_BITS-1:0] pass_mask,
  input  logic                 si_fas_val,
  input  logic [SLOT_BITS-1:0] nfas_val,
  output bit_src_e             bit_src,
  output logic                 reg_bit,
  output logic                 sa_pos,
  output logic                 frm_start,
  output logic                 mf_start
);

  logic [TS_W-1:0]  ts;
  logic [BIT_W-1:0] bidx;
  logic             is_ts0;
  logic             is_sig_ts;
  logic             odd_frm;

  assign ts        = cur_pos[POS_W-1:BIT_W];
  assign bidx      = cur_pos[BIT_W-1:0];
  assign is_ts0    = (ts == '0);
  assign is_sig_ts = (ts == TS_W'(SIG_TS));
  assign odd_frm   = cur_frm[0];

  always_comb begin
    bit_src = (is_sig_ts || (is_ts0 && cas_serial_en)) ? SRC_SIG : SRC_DATA;
    reg_bit = 1'b0;
    if (is_ts0) begin
      if (!odd_frm) begin
        // alignment frame: only the international bit may be inserted
        if ((bidx == '0) && !pass_mask[0]) begin
          bit_src = SRC_REG;
          reg_bit = si_fas_val;
        end
      end else if (!pass_mask[bidx]) begin
        bit_src = SRC_REG;
        reg_bit = nfas_val[bidx];
      end
    end
  end

  assign sa_pos    = is_ts0 && odd_frm && (bidx >= BIT_W'(SA_FIRST));
  assign frm_start = (cur_pos == '0);
  assign mf_start  = (cur_pos == '0) && (cur_frm == '0);

endmodule

// File: rtl/e1_hwy_out.sv
module e1_hwy_out
  import e1_hwy_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     data_in,
  input  logic     sig_in,
  input  bit_src_e bit_src,
  input  logic     reg_bit,
  input  logic     sa_pos,
  input  logic     frm_start,
  input  logic     mf_start,
  output logic     tx_out,
  output logic     sa_mark_out,
  output logic     frame_start_out,
  output logic     mf_start_out
);

  logic tx_d;

  always_comb begin
    case (bit_src)
      SRC_SIG: tx_d = sig_in;
      SRC_REG: tx_d = reg_bit;
      default: tx_d = data_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_out          <= 1'b0;
      sa_mark_out     <= 1'b0;
      frame_start_out <= 1'b0;
      mf_start_out    <= 1'b0;
    end else begin
      tx_out          <= tx_d;
      sa_mark_out     <= sa_pos;
      frame_start_out <= frm_start;
      mf_start_out    <= mf_start;
    end
  end

endmodule

// File: rtl/e1_tx_hwy_merge.sv
module e1_tx_hwy_merge
  import e1_hwy_pkg::*;
#(
  parameter int SLOTS      = 32,
  parameter int SLOT_BITS  = 8,
  parameter int FRAMES     = 16,
  parameter int SIG_TS     = 16,
  parameter int SA_FIRST   = 3,
  localparam int FRAME_BITS = SLOTS * SLOT_BITS,
  localparam int POS_W      = $clog2(FRAME_BITS),
  localparam int FRM_W      = $clog2(FRAMES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 data_in,
  input  logic                 sig_in,
  input  logic                 sync_in,
  input  logic                 cas_serial_en,
  input  logic [POS_W-1:0]     ts_offset,
  input  logic [SLOT_BITS-1:0] pass_mask,
  input  logic                 si_fas_val,
  input  logic [SLOT_BITS-1:0] nfas_val,
  output logic                 tx_out,
  output logic                 sa_mark_out,
  output logic                 frame_start_out,
  output logic                 mf_start_out
);

  logic [POS_W-1:0] cur_pos;
  logic [FRM_W-1:0] cur_frm;
  bit_src_e         bit_src;
  logic             reg_bit;
  logic             sa_pos;
  logic             frm_start;
  logic             mf_start;

  e1_hwy_pos_cnt #(
    .FRAME_BITS (FRAME_BITS),
    .FRAMES     (FRAMES)
  ) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .sync_in (sync_in),
    .ofs     (ts_offset),
    .cur_pos (cur_pos),
    .cur_frm (cur_frm)
  );

  e1_hwy_ts0_ins #(
    .SLOTS     (SLOTS),
    .SLOT_BITS (SLOT_BITS),
    .FRAMES    (FRAMES),
    .SIG_TS    (SIG_TS),
    .SA_FIRST  (SA_FIRST)
  ) u_sel (
    .cur_pos       (cur_pos),
    .cur_frm       (cur_frm),
    .cas_serial_en (cas_serial_en),
    .pass_mask     (pass_mask),
    .si_fas_val    (si_fas_val),
    .nfas_val      (nfas_val),
    .bit_src       (bit_src),
    .reg_bit       (reg_bit),
    .sa_pos        (sa_pos),
    .frm_start     (frm_start),
    .mf_start      (mf_start)
  );

  e1_hwy_out u_out (
    .clk             (clk),
    .rst             (rst),
    .data_in         (data_in),
    .sig_in          (sig_in),
    .bit_src         (bit_src),
    .reg_bit         (reg_bit),
    .sa_pos          (sa_pos),
    .frm_start       (frm_start),
    .mf_start        (mf_start),
    .tx_out          (tx_out),
    .sa_mark_out     (sa_mark_out),
    .frame_start_out (frame_start_out),
    .mf_start_out    (mf_start_out)
  );

endmodule

// File: rtl/e1_tx_hwy_merge_chk.sv
module e1_tx_hwy_merge_chk #(
  parameter int SLOTS      = 32,
  parameter int SLOT_BITS  = 8,
  parameter int FRAMES     = 16,
  parameter int SIG_TS     = 16,
  localparam int POS_W     = $clog2(SLOTS * SLOT_BITS),
  localparam int FRM_W     = $clog2(FRAMES),
  localparam int BIT_W     = $clog2(SLOT_BITS),
  localparam int TS_W      = POS_W - BIT_W
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 data_in,
  input logic                 sig_in,
  input logic                 sync_in,
  input logic                 cas_serial_en,
  input logic [SLOT_BITS-1:0] pass_mask,
  input logic [POS_W-1:0]     cur_pos,
  input logic [FRM_W-1:0]     cur_frm,
  input logic                 tx_out,
  input logic                 sa_mark_out,
  input logic                 frame_start_out,
  input logic                 mf_start_out
);

  logic [TS_W-1:0]  ts;
  logic [BIT_W-1:0] bidx;
  assign ts   = cur_pos[POS_W-1:BIT_W];
  assign bidx = cur_pos[BIT_W-1:0];

  a_r2_data_slots: assert property (@(posedge clk) disable iff (rst)
    (ts != '0 && ts != TS_W'(SIG_TS)) |=> (tx_out == $past(data_in)));

  a_r3_ts16_sig: assert property (@(posedge clk) disable iff (rst)
    (ts == TS_W'(SIG_TS)) |=> (tx_out == $past(sig_in)));

  a_r4_ts0_pass: assert property (@(posedge clk) disable iff (rst)
    (ts == '0 && pass_mask[bidx])
      |=> (tx_out == ($past(cas_serial_en) ? $past(sig_in) : $past(data_in))));

  a_r8_pos_wrap: assert property (@(posedge clk) disable iff (rst)
    (cur_pos == POS_W'(SLOTS * SLOT_BITS - 1)) |=> (sync_in || cur_pos == '0));

  a_r8_frm_wrap: assert property (@(posedge clk) disable iff (rst)
    (cur_pos == POS_W'(SLOTS * SLOT_BITS - 1) && cur_frm == FRM_W'(FRAMES - 1))
      |=> (sync_in || cur_frm == '0));

  a_r8_mf_in_frame: assert property (@(posedge clk) disable iff (rst)
    mf_start_out |-> frame_start_out);

  a_r9_mark_ts0_odd: assert property (@(posedge clk) disable iff (rst)
    sa_mark_out |-> ($past(ts) == '0 && $past(cur_frm[0]) && !frame_start_out));

endmodule

bind e1_tx_hwy_merge e1_tx_hwy_merge_chk #(
  .SLOTS     (SLOTS),
  .SLOT_BITS (SLOT_BITS),
  .FRAMES    (FRAMES),
  .SIG_TS    (SIG_TS)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .data_in         (data_in),
  .sig_in          (sig_in),
  .sync_in         (sync_in),
  .cas_serial_en   (cas_serial_en),
  .pass_mask       (pass_mask),
  .cur_pos         (cur_pos),
  .cur_frm         (cur_frm),
  .tx_out          (tx_out),
  .sa_mark_out     (sa_mark_out),
  .frame_start_out (frame_start_out),
  .mf_start_out    (mf_start_out)
);

// File: tb/e1_tx_hwy_merge_tb_top.sv
module e1_tx_hwy_merge_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       data_in = 1'b0;
  logic       sig_in = 1'b0;
  logic       sync_in = 1'b0;
  logic       cas_serial_en = 1'b0;
  logic [7:0] ts_offset = 8'd0;
  logic [7:0] pass_mask = 8'hFF;
  logic       si_fas_val = 1'b0;
  logic [7:0] nfas_val = 8'h00;
  logic       tx_out, sa_mark_out, frame_start_out, mf_start_out;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int sync_c = 0;
  int sync_o = 0;
  int phase_no = 0;
  bit have_prev = 1'b0;
  bit done = 1'b0;

  logic  e_tx, e_sa, e_fs, e_mf;
  string e_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  e1_tx_hwy_merge dut_i (
    .clk             (clk),
    .rst             (rst),
    .data_in         (data_in),
    .sig_in          (sig_in),
    .sync_in         (sync_in),
    .cas_serial_en   (cas_serial_en),
    .ts_offset       (ts_offset),
    .pass_mask       (pass_mask),
    .si_fas_val      (si_fas_val),
    .nfas_val        (nfas_val),
    .tx_out          (tx_out),
    .sa_mark_out     (sa_mark_out),
    .frame_start_out (frame_start_out),
    .mf_start_out    (mf_start_out)
  );

  function automatic logic pat_d(int c);
    return logic'(((c * 5) ^ (c >> 2) ^ (c >> 5)) & 1);
  endfunction

  function automatic logic pat_s(int c);
    return logic'(((c * 3) ^ (c >> 1) ^ (c >> 4) ^ 1) & 1);
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", req, what, cyc, act, exp);
    end
  endtask

  // Drive inputs for the coming edge and compute the expected outputs
  task automatic drive(bit do_sync);
    int relp, pos, fr, ts, b;
    logic d, s, src;
    rst     = 1'b0;
    d       = pat_d(cyc);
    s       = pat_s(cyc);
    data_in = d;
    sig_in  = s;
    sync_in = do_sync;
    relp = cyc - sync_c - sync_o + 256 * 16 * 64;
    pos  = relp % 256;
    fr   = (relp / 256) % 16;
    ts   = pos / 8;
    b    = pos % 8;
    src  = (ts == 16 || (ts == 0 && cas_serial_en)) ? s : d;
    e_tx = src;
    if (ts == 16) e_tag = "R3";
    else if (ts != 0) e_tag = "R2";
    else if (fr % 2 == 0) begin
      e_tag = "R5/R4";
      if (b == 0 && !pass_mask[0]) e_tx = si_fas_val;
    end else begin
      e_tag = "R6/R4";
      if (!pass_mask[b]) e_tx = nfas_val[b];
    end
    if (phase_no == 0) e_tag = "R1";
    e_sa = (ts == 0 && fr % 2 == 1 && b >= 3);
    e_fs = (pos == 0);
    e_mf = (pos == 0 && fr == 0);
    have_prev = 1'b1;
    cyc++;
  endtask

  task automatic check_prev();
    if (have_prev) begin
      chk(e_tag, "tx_out", tx_out, e_tx);
      chk("R9", "sa_mark_out", sa_mark_out, e_sa);
      chk((phase_no == 0) ? "R1" : "R7", "frame_start_out", frame_start_out, e_fs);
      chk("R8", "mf_start_out", mf_start_out, e_mf);
    end
  endtask

  task automatic run_phase(int pno, bit do_sync, int ofs, bit cas, logic [7:0] msk,
                           logic si, logic [7:0] nf, int ncyc);
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      check_prev();
      if (i == 0) begin
        phase_no      = pno;
        ts_offset     = 8'(ofs);
        cas_serial_en = cas;
        pass_mask     = msk;
        si_fas_val    = si;
        nfas_val      = nf;
        sync_c        = cyc;
        sync_o        = do_sync ? ofs : 0;
      end
      drive(do_sync && i == 0);
    end
  endtask

  initial begin
    // R1: outputs held low while reset is asserted
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk("R1", "tx_out in reset", tx_out, 1'b0);
        chk("R1", "sa_mark_out in reset", sa_mark_out, 1'b0);
        chk("R1", "frame_start_out in reset", frame_start_out, 1'b0);
        chk("R1", "mf_start_out in reset", mf_start_out, 1'b0);
      end
    end
    run_phase(0, 1'b0, 0,   1'b0, 8'hFF, 1'b0, 8'h00, 600);
    run_phase(1, 1'b1, 0,   1'b0, 8'hFF, 1'b0, 8'h00, 4096 + 300);
    run_phase(2, 1'b1, 37,  1'b1, 8'h00, 1'b1, 8'hA5, 700);
    run_phase(3, 1'b1, 255, 1'b0, 8'h0F, 1'b0, 8'h3C, 700);
    run_phase(4, 1'b1, 1,   1'b1, 8'h96, 1'b1, 8'h5A, 4096 + 400);
    @(negedge clk);
    check_prev();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule